// File: doc/BRIEF.md
# Redundant Clock Role Switch Controller

This block decides the role of one clock unit in a redundant pair. An external role pin sets the role. The block never picks a role by itself. The pin passes through a two-flop synchronizer and a stability filter. The filtered role then drives a four-state sequencer that tells the downstream phase tracker what to follow. As master, the tracker follows the locally selected reference. As slave, it follows the clock cross-coupled from the partner unit, and it applies no frequency slew limit.

Each direction of changeover has its own hitless step.

- **Slave to master:** the block holds the output and emits a single-cycle build-out strobe. The tracker uses that strobe to re-base the local reference onto the present output phase.
- **Master to slave:** the block holds the output for one millisecond before switching to the cross input. Returning to master during that hold cancels it.

The first slave entry after reset skips the hold, because the output phase is not yet aligned to anything. Instead the block raises a pull-in flag so that the tracker converges in steps.

A signed 8-bit skew value is forwarded to the tracker only while following the cross input. It compensates for trace delay.

Top module: `role_switch_ctrl`

## Requirements
- R1: The role is taken only from `role_pin_i` (1 = master, 0 = slave). The pin is resynchronized by two flops and acted on only after the synchronized level has differed from the current role for 16 consecutive cycles. A pulse of 10 cycles has no effect.
- R2: In the master states, `follow_cross_o` is 0. In the tracking-slave state, `follow_cross_o` is 1. `follow_cross_o` is never 1 while `hold_o` is 1.
- R3: `skew_o` equals `skew_cfg_i` while tracking as slave, and is 0 otherwise. The value is two's complement in 0.25 ns steps: 0x80 is -32 ns and 0x7F is +31.75 ns.
- R4: On a change from tracking-slave to master, the block enters building-out for `BO_CYCLES` cycles (default 8) with `hold_o` = 1 and `follow_cross_o` = 0. `buildout_stb_o` is high for exactly one cycle, the first cycle of that state. The block then returns to idle-master.
- R5: On a change from master to slave, other than the first since reset, the block stays in hold-slave for exactly `CLK_HZ/1000` cycles with `hold_o` = 1 and `follow_cross_o` = 0. It then enters tracking-slave.
- R6: If the filtered role returns to master during hold-slave, the block goes straight back to idle-master with no build-out strobe.
- R7: The first slave entry after reset goes directly to tracking-slave with no hold. `pull_in_o` = 1 for the whole of that stay and 0 at all other times.
- R8: `status_o` encodes idle-master as 0, building-out as 1, hold-slave as 2 and tracking-slave as 3.
- R9: While `rst_n` is low and after its release, the block is in idle-master with `hold_o`, `buildout_stb_o`, `follow_cross_o`, `pull_in_o` and `skew_o` all zero, and the first-slave pull-in is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_pin_i | input | 1 | Asynchronous role pin, 1 = master |
| skew_cfg_i | input | 8 | Signed slave skew, 0.25 ns per step |
| hold_o | output | 1 | Tracker must hold output phase and frequency |
| buildout_stb_o | output | 1 | One-cycle request for phase build-out on the local reference |
| follow_cross_o | output | 1 | 1 = track partner cross input, 0 = track local reference |
| skew_o | output | 8 | Skew applied by the tracker, zero unless following cross input |
| pull_in_o | output | 1 | First-entry stepwise convergence in progress |
| status_o | output | 2 | Sequencer state code |

## Verification
A sequencer in the wrong state appears at once on `status_o`, and within the same cycle on `hold_o` and `follow_cross_o`. A stuck or miscounted hold timer shows as a hold-slave interval that differs from `CLK_HZ/1000` cycles. A faulty role filter shows either as a role change after a short pin pulse or as a delay far from 18 cycles after a clean pin edge. Either way it is visible within a few tens of cycles. A wrongly timed or repeated build-out strobe, or a skew leaking out in master role, shows in the cycle it occurs, because every strobe cycle and every held cycle is tallied at the ports.

// File: rtl/rsw_pkg.sv
// Shared types for the role switch controller.
package rsw_pkg;
    // Sequencer state; the code is visible on status_o and is part of R8.
    typedef enum logic [1:0] {
        ST_MASTER = 2'd0,
        ST_BUILD  = 2'd1,
        ST_HOLD   = 2'd2,
        ST_TRACK  = 2'd3
    } rsw_state_t;
endpackage

// File: rtl/rsw_role_filter.sv
// Role pin conditioner.
// Resynchronizes the asynchronous role pin with two flops, then accepts a
// new level only after it has differed from the accepted role for STABLE
// consecutive cycles. Assumes the pin is quasi-static. Reset role is master.
module rsw_role_filter #(
    parameter int STABLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic role_master_o
);
    localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;

    logic          sync1_q, sync2_q, role_q;
    logic [CW-1:0] run_q;

    // Two-flop synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
        end
    end

    // Count consecutive disagreeing cycles and adopt the new role at STABLE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_q <= 1'b1;
            run_q  <= '0;
        end else if (sync2_q == role_q) begin
            run_q <= '0;
        end else if (run_q == CW'(STABLE - 1)) begin
            role_q <= sync2_q;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign role_master_o = role_q;
endmodule

// File: rtl/rsw_down_timer.sv
// Loadable down counter shared by the hold and build-out intervals.
// A load takes priority. The counter stops at zero, and zero_o is high
// while the count is zero.
module rsw_down_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_q;

    // Load or decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rsw_seq_fsm.sv
// Changeover sequencer.
// Moves between idle-master, building-out, hold-slave and tracking-slave
// from the filtered role and the interval timer. The interval is loaded on
// entry to hold or build-out, so a state lasts (load value + 1) cycles.
// Assumes HOLD_CYC >= 1 and BO_CYC >= 1. A role change seen during
// build-out waits until build-out has finished.
module rsw_seq_fsm
    import rsw_pkg::*;
#(
    parameter int HOLD_CYC = 1000,
    parameter int BO_CYC   = 8,
    parameter int TW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          role_master_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output rsw_state_t    state_o,
    output logic          strobe_o,
    output logic          pull_in_o
);
    rsw_state_t state_q, state_d;
    logic       first_done_q, pull_q, strobe_q;

    // Next-state and timer-load decision.
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            ST_MASTER: if (!role_master_i) begin
                if (first_done_q) begin
                    state_d    = ST_HOLD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TW'(HOLD_CYC - 1);
                end else begin
                    state_d = ST_TRACK;
                end
            end
            ST_HOLD: begin
                if (role_master_i)   state_d = ST_MASTER;
                else if (tmr_zero_i) state_d = ST_TRACK;
            end
            ST_TRACK: if (role_master_i) begin
                state_d    = ST_BUILD;
                tmr_load_o = 1'b1;
                tmr_val_o  = TW'(BO_CYC - 1);
            end
            ST_BUILD: if (tmr_zero_i) state_d = ST_MASTER;
            default:  state_d = ST_MASTER;
        endcase
    end

    // State register plus first-entry, pull-in and strobe flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_MASTER;
            first_done_q <= 1'b0;
            pull_q       <= 1'b0;
            strobe_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            strobe_q <= (state_q == ST_TRACK) && (state_d == ST_BUILD);
            if (state_q == ST_MASTER && state_d == ST_TRACK) begin
                first_done_q <= 1'b1;
                pull_q       <= 1'b1;
            end else if (state_q == ST_MASTER && state_d == ST_HOLD) begin
                first_done_q <= 1'b1;
            end
            if (state_q == ST_TRACK && state_d != ST_TRACK) pull_q <= 1'b0;
        end
    end

    assign state_o   = state_q;
    assign strobe_o  = strobe_q;
    assign pull_in_o = pull_q;
endmodule

// File: rtl/role_switch_ctrl.sv
// Role switch controller for one unit of a redundant clock pair.
// Conditions the role pin, sequences hitless changeovers and drives the
// phase tracker's hold, build-out, source-select and skew inputs.
// Assumes CLK_HZ is a multiple of 1000, so that 1 ms is CLK_HZ/1000 cycles.
module role_switch_ctrl #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int STABLE    = 16,
    parameter int BO_CYCLES = 8,
    parameter int SKEW_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              role_pin_i,
    input  logic [SKEW_W-1:0] skew_cfg_i,
    output logic              hold_o,
    output logic              buildout_stb_o,
    output logic              follow_cross_o,
    output logic [SKEW_W-1:0] skew_o,
    output logic              pull_in_o,
    output logic [1:0]        status_o
);
    import rsw_pkg::*;

    localparam int HOLD_CYC = CLK_HZ / 1000;
    localparam int MAX_IVL  = (HOLD_CYC > BO_CYCLES) ? HOLD_CYC : BO_CYCLES;
    localparam int TW       = $clog2(MAX_IVL + 1);

    logic          role_master, tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    rsw_state_t    state;

    rsw_role_filter #(.STABLE(STABLE)) u_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_i         (role_pin_i),
        .role_master_o (role_master)
    );

    rsw_down_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    rsw_seq_fsm #(.HOLD_CYC(HOLD_CYC), .BO_CYC(BO_CYCLES), .TW(TW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .role_master_i (role_master),
        .tmr_zero_i    (tmr_zero),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .state_o       (state),
        .strobe_o      (buildout_stb_o),
        .pull_in_o     (pull_in_o)
    );

    // Output decode from the sequencer state.
    always_comb begin
        hold_o         = (state == ST_HOLD) || (state == ST_BUILD);
        follow_cross_o = (state == ST_TRACK);
        skew_o         = (state == ST_TRACK) ? skew_cfg_i : '0;
        status_o       = state;
    end
endmodule

// File: rtl/rsw_chk.sv
// Port-level property checker for role_switch_ctrl, attached with bind.
// Counts hold-slave cycles itself so that the 1 ms window needs no deep $past.
module rsw_chk #(
    parameter int CLK_HZ = 100_000_000,
    parameter int SKEW_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_o,
    input logic              buildout_stb_o,
    input logic              follow_cross_o,
    input logic [SKEW_W-1:0] skew_o,
    input logic              pull_in_o,
    input logic [1:0]        status_o
);
    localparam int HOLD_CYC = CLK_HZ / 1000;
    localparam int HW       = $clog2(HOLD_CYC + 2);

    logic [HW-1:0] hold_run_q;

    // Consecutive hold-slave cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_run_q <= '0;
        else if (status_o == 2'd2) hold_run_q <= hold_run_q + 1'b1;
        else                     hold_run_q <= '0;
    end

    assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buildout_stb_o |=> !buildout_stb_o);
    assert_stb_in_build_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buildout_stb_o |-> (status_o == 2'd1) && hold_o && !follow_cross_o);
    assert_hold_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd3 && $past(status_o) == 2'd2) |-> hold_run_q == HW'(HOLD_CYC));
    assert_no_cross_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> !follow_cross_o);
    assert_skew_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !follow_cross_o |-> skew_o == '0);
    assert_cancel_no_build_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_o) == 2'd2) |-> status_o != 2'd1);
    assert_pull_only_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pull_in_o |-> status_o == 2'd3);
endmodule

bind role_switch_ctrl rsw_chk #(.CLK_HZ(CLK_HZ), .SKEW_W(SKEW_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hold_o         (hold_o),
    .buildout_stb_o (buildout_stb_o),
    .follow_cross_o (follow_cross_o),
    .skew_o         (skew_o),
    .pull_in_o      (pull_in_o),
    .status_o       (status_o)
);

// File: tb/role_switch_ctrl_tb.sv
// Bench: table-driven role sequence, then directed reset and corner cases.
module role_switch_ctrl_tb;
    localparam int CLK_HZ = 100_000;         // hold = 100 cycles
    localparam int HOLD   = CLK_HZ / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       role_pin = 1'b1;
    logic [7:0] skew_cfg = 8'h00;
    logic       hold_o, stb_o, follow_o, pull_o;
    logic [7:0] skew_o;
    logic [1:0] status_o;

    int checks = 0;
    int fails = 0;
    int stb_cnt = 0;
    int build_ok_cnt = 0;
    int hold_seen = 0;
    int hold_run = 0;
    int last_hold_len = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    role_switch_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .role_pin_i(role_pin), .skew_cfg_i(skew_cfg),
        .hold_o(hold_o), .buildout_stb_o(stb_o), .follow_cross_o(follow_o),
        .skew_o(skew_o), .pull_in_o(pull_o), .status_o(status_o)
    );

    // Port monitor sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb_o) stb_cnt++;
            if (status_o == 2'd1 && hold_o && !follow_o) build_ok_cnt++;
            if (status_o == 2'd2) begin
                hold_seen++;
                hold_run++;
            end else begin
                if (hold_run != 0 && status_o == 2'd3) last_hold_len = hold_run;
                hold_run = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Vector: pin, skew, wait, status, follow, hold, skew_o, pull
    localparam logic [37:0] VEC [6] = '{
        {1'b1, 8'h10, 16'd5,  2'd0, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h10, 16'd25, 2'd3, 1'b1, 1'b0, 8'h10, 1'b1},
        {1'b0, 8'h80, 16'd3,  2'd3, 1'b1, 1'b0, 8'h80, 1'b1},
        {1'b1, 8'h80, 16'd40, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h7F, 16'd60, 2'd2, 1'b0, 1'b1, 8'h00, 1'b0},
        {1'b0, 8'h7F, 16'd80, 2'd3, 1'b1, 1'b0, 8'h7F, 1'b0}
    };

    initial begin
        int snap;
        cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 status", status_o, 0);
        chk("R9 hold", hold_o, 0);
        chk("R9 follow", follow_o, 0);
        chk("R9 strobe", stb_o, 0);

        for (int i = 0; i < 6; i++) begin
            role_pin = VEC[i][37];
            skew_cfg = VEC[i][36:29];
            cyc(int'(VEC[i][28:13]));
            chk($sformatf("R8 status v%0d", i), status_o, int'(VEC[i][12:11]));
            chk($sformatf("R2 follow v%0d", i), follow_o, int'(VEC[i][10]));
            chk($sformatf("R5 hold v%0d", i), hold_o, int'(VEC[i][9]));
            chk($sformatf("R3 skew v%0d", i), skew_o, int'(VEC[i][8:1]));
            chk($sformatf("R7 pull v%0d", i), pull_o, int'(VEC[i][0]));
        end
        chk("R5 hold length", last_hold_len, HOLD);
        chk("R4 one strobe", stb_cnt, 1);

        // R3 signed code 0x80 means -32 ns
        skew_cfg = 8'h80;
        cyc(1);
        chk("R3 skew ps", $signed(skew_o) * 250, -32000);

        // R4 second build-out: one more strobe, 8 held cycles each
        role_pin = 1'b1;
        cyc(40);
        chk("R4 status", status_o, 0);
        chk("R4 strobe count", stb_cnt, 2);
        chk("R4 build cycles", build_ok_cnt, 16);

        // R6 cancel during hold
        role_pin = 1'b0;
        cyc(40);
        chk("R6 in hold", status_o, 2);
        role_pin = 1'b1;
        cyc(30);
        chk("R6 back master", status_o, 0);
        chk("R6 no strobe", stb_cnt, 2);

        // R1 short pulse ignored
        snap = hold_seen;
        role_pin = 1'b0;
        cyc(10);
        role_pin = 1'b1;
        cyc(30);
        chk("R1 still master", status_o, 0);
        chk("R1 no hold", hold_seen, snap);

        // R1 clean edge: unchanged at 15 cycles, acted on by 20
        role_pin = 1'b0;
        cyc(15);
        chk("R1 not yet", status_o, 0);
        cyc(5);
        chk("R1 acted", status_o, 2);
        cyc(HOLD + 10);
        chk("R5 full hold", last_hold_len, HOLD);
        chk("R7 pull not first", pull_o, 0);

        // R9 reset mid-track re-arms first entry (R7)
        rst_n = 1'b0;
        cyc(3);
        chk("R9 status in reset", status_o, 0);
        chk("R9 skew in reset", skew_o, 0);
        rst_n = 1'b1;
        cyc(25);
        chk("R7 first entry track", status_o, 3);
        chk("R7 pull re-armed", pull_o, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule